// File: doc/BRIEF.md
# PCM Time-Slot Serial Port

The block moves one 8-bit PCM sample per frame in each direction over a shared serial backplane. A single clock acts as both the system clock and the bit clock. A frame-sync pulse restarts a bit-position counter. Every group of eight consecutive bit positions forms one time slot. Two independent slot numbers select where the outgoing byte is placed and where the incoming byte is taken from. The frame length comes from a 2-bit rate code, so the number of slots per frame follows the bit-clock rate in use.

In its transmit slot the block drives its byte onto the serial output, most significant bit first. It raises an output-enable for the data pin and pulls its active-low line-driver strobe low. The enable and the pull-low flag stand in for real tri-state and open-drain pads. In its receive slot it samples the serial input on the falling clock edge. When the eighth bit has been sampled, it places the byte in a holding register and raises a one-cycle valid pulse.

Three small state machines do the work:
- **Frame sync machine:** `SYNC_HUNT` (after reset, no frame seen yet) moves to `SYNC_LOCK` on the first frame sync and then stays there.
- **Transmit machine:** `TX_IDLE` moves to `TX_SEND` at any clock edge that starts a position inside the transmit slot. `TX_SEND` returns to `TX_IDLE` at the first edge that starts a position outside it.
- **Receive machine:** `RX_IDLE` and `RX_SHIFT` follow the receive slot with the same entry and exit conditions. The last bit in `RX_SHIFT` completes the byte.

Top module: `pcm_slot_port`

## Requirements
- R1: During and after reset, `dx_oe` is 0, `tsx_n` is 1, `rx_valid` is 0 and `rx_data` is 0. Until the first `fsync` is sampled high, no slot is active, whatever the other inputs do.
- R2: The rising edge that samples `fsync` high starts bit position 0 in the following cycle. Without another `fsync`, the position count wraps to 0 after the frame length. The frame length is set by `rate_sel`: 0 gives 192, 1 gives 256, 2 gives 512 and 3 gives 1024 bit clocks.
- R3: Slot n covers bit positions 8n to 8n+7. `dx_oe` is 1 in exactly the eight cycles of the transmit slot. In those cycles `dx` carries the transmit byte, most significant bit first, changing only at rising edges.
- R4: `tsx_n` is 0 exactly in the cycles where `dx_oe` is 1, and 1 at all other times.
- R5: The byte sent is the value of `tx_data` at the frame-sync edge. Changes to `tx_data` later in the frame have no effect on `dx`.
- R6: In each cycle of the receive slot, `dr` is sampled at the falling clock edge, MSB first. In the cycle after the slot's last position, `rx_data` holds the sampled byte and `rx_valid` is 1 for that cycle only.
- R7: Outside the receive slot, `dr` is ignored: `rx_data` keeps its value and `rx_valid` stays 0.
- R8: A transmit or receive slot number equal to or above frame length / 8 disables that direction for the frame. The other direction is not affected.
- R9: `rate_sel`, `tx_slot` and `rx_slot` take effect only at the frame-sync edge. Changes later in the frame are not seen until the next `fsync`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, also the serial bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fsync | input | 1 | Frame-sync pulse, one clock wide |
| rate_sel | input | 2 | Frame length code, latched at frame sync |
| tx_slot | input | SLOT_W | Transmit slot number, latched at frame sync |
| rx_slot | input | SLOT_W | Receive slot number, latched at frame sync |
| tx_data | input | 8 | Byte to send, latched at frame sync |
| dr | input | 1 | Serial receive data |
| dx | output | 1 | Serial transmit data, meaningful only while `dx_oe` is 1 |
| dx_oe | output | 1 | Output enable for the transmit data pin |
| tsx_n | output | 1 | Active-low line-driver strobe (0 = pulled low) |
| rx_data | output | 8 | Last byte received |
| rx_valid | output | 1 | One-cycle pulse when `rx_data` is updated |

## Verification
The main path is swept over every transmit slot of the 192-bit frame, with the receive slot moved to a different place in each frame. For all four rates the bench also uses these slot pairs:
- first and last slot together, which shows whether the counter wraps at the right length;
- both directions on the same slot;
- each direction on its own set to a disabling number.

Between frame syncs, the bench changes the transmit byte, the slot numbers and the rate code. This separates values latched at frame sync from values that follow the inputs. Outside the receive slot, `dr` carries a pattern that differs from the expected byte, so any leak into the holding register shows up on `rx_data`.

// File: rtl/pcm_slot_pkg.sv
`timescale 1ns/1ps
package pcm_slot_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [0:0] {SYNC_HUNT, SYNC_LOCK} sync_state_t;
    typedef enum logic [0:0] {TX_IDLE, TX_SEND} tx_state_t;
    typedef enum logic [0:0] {RX_IDLE, RX_SHIFT} rx_state_t;

    // Frame length in bit clocks for a rate code.
    function automatic int unsigned frame_bits(input logic [1:0] rate);
        int unsigned len;
        case (rate)
            2'd0:    len = 192;
            2'd1:    len = 256;
            2'd2:    len = 512;
            default: len = 1024;
        endcase
        return len;
    endfunction

endpackage

// File: rtl/pcm_frame_counter.sv
`timescale 1ns/1ps
module pcm_frame_counter
    import pcm_slot_pkg::*;
#(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fsync,
    input  logic [CNT_W-1:0] last_pos,
    output logic [CNT_W-1:0] cnt_next,
    output logic [2:0]       cur_bit,
    output logic             active_next
);

    sync_state_t      state_q, state_d;
    logic [CNT_W-1:0] cnt_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SYNC_HUNT: if (fsync) state_d = SYNC_LOCK;
            SYNC_LOCK: state_d = SYNC_LOCK;
        endcase
    end

    always_comb begin
        if (fsync) begin
            cnt_next = '0;
        end else if (cnt_q >= last_pos) begin
            cnt_next = '0;
        end else begin
            cnt_next = cnt_q + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SYNC_HUNT;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_next;
        end
    end

    always_comb begin
        active_next = (state_d == SYNC_LOCK);
        cur_bit     = cnt_q[2:0];
    end

endmodule

// File: rtl/pcm_tx_lane.sv
`timescale 1ns/1ps
module pcm_tx_lane
    import pcm_slot_pkg::*;
#(
    parameter int CNT_W  = 10,
    parameter int SLOT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active_next,
    input  logic [CNT_W-1:0]  cnt_next,
    input  logic [SLOT_W-1:0] slot,
    input  logic [SLOT_W:0]   slots_in_frame,
    input  logic [BYTE_W-1:0] load_byte,
    output logic              dx,
    output logic              dx_oe
);

    tx_state_t         state_q, state_d;
    logic [BYTE_W-1:0] shreg_q;
    logic              slot_ok;
    logic              hit_next;
    logic              slot_start;

    always_comb begin
        slot_ok    = ({1'b0, slot} < slots_in_frame);
        hit_next   = active_next && slot_ok && (SLOT_W'(cnt_next >> 3) == slot);
        slot_start = hit_next && (cnt_next[2:0] == 3'd0);
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_IDLE: if (hit_next)  state_d = TX_SEND;
            TX_SEND: if (!hit_next) state_d = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TX_IDLE;
            shreg_q <= '0;
        end else begin
            state_q <= state_d;
            if (slot_start) begin
                shreg_q <= load_byte;
            end else if (state_q == TX_SEND) begin
                shreg_q <= {shreg_q[BYTE_W-2:0], 1'b0};
            end
        end
    end

    always_comb begin
        dx_oe = (state_q == TX_SEND);
        dx    = dx_oe ? shreg_q[BYTE_W-1] : 1'b0;
    end

endmodule

// File: rtl/pcm_rx_lane.sv
`timescale 1ns/1ps
module pcm_rx_lane
    import pcm_slot_pkg::*;
#(
    parameter int CNT_W  = 10,
    parameter int SLOT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active_next,
    input  logic [CNT_W-1:0]  cnt_next,
    input  logic [2:0]        cur_bit,
    input  logic [SLOT_W-1:0] slot,
    input  logic [SLOT_W:0]   slots_in_frame,
    input  logic              dr,
    output logic [BYTE_W-1:0] rx_data,
    output logic              rx_valid
);

    rx_state_t         state_q, state_d;
    logic [BYTE_W-1:0] shreg_q;
    logic [BYTE_W-1:0] data_q;
    logic              valid_q;
    logic              dr_fall_q;
    logic              slot_ok;
    logic              hit_next;
    logic              byte_done;

    // Serial input is captured half a clock after each bit starts.
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dr_fall_q <= 1'b0;
        end else begin
            dr_fall_q <= dr;
        end
    end

    always_comb begin
        slot_ok   = ({1'b0, slot} < slots_in_frame);
        hit_next  = active_next && slot_ok && (SLOT_W'(cnt_next >> 3) == slot);
        byte_done = (state_q == RX_SHIFT) && (cur_bit == 3'(BYTE_W - 1));
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_IDLE:  if (hit_next)  state_d = RX_SHIFT;
            RX_SHIFT: if (!hit_next) state_d = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RX_IDLE;
            shreg_q <= '0;
            data_q  <= '0;
            valid_q <= 1'b0;
        end else begin
            state_q <= state_d;
            valid_q <= byte_done;
            if (state_q == RX_SHIFT) begin
                shreg_q <= {shreg_q[BYTE_W-2:0], dr_fall_q};
            end
            if (byte_done) begin
                data_q <= {shreg_q[BYTE_W-2:0], dr_fall_q};
            end
        end
    end

    always_comb begin
        rx_data  = data_q;
        rx_valid = valid_q;
    end

endmodule

// File: rtl/pcm_slot_port.sv
`timescale 1ns/1ps
module pcm_slot_port
    import pcm_slot_pkg::*;
#(
    parameter int SLOT_W   = 8,
    parameter int MAX_BITS = 1024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fsync,
    input  logic [1:0]        rate_sel,
    input  logic [SLOT_W-1:0] tx_slot,
    input  logic [SLOT_W-1:0] rx_slot,
    input  logic [BYTE_W-1:0] tx_data,
    input  logic              dr,
    output logic              dx,
    output logic              dx_oe,
    output logic              tsx_n,
    output logic [BYTE_W-1:0] rx_data,
    output logic              rx_valid
);

    localparam int CNT_W = $clog2(MAX_BITS);

    logic [1:0]        rate_q, rate_eff;
    logic [SLOT_W-1:0] txs_q, txs_eff;
    logic [SLOT_W-1:0] rxs_q, rxs_eff;
    logic [BYTE_W-1:0] txd_q, txd_eff;
    logic [CNT_W:0]    frame_len;
    logic [CNT_W-1:0]  last_pos;
    logic [SLOT_W:0]   slots_in_frame;
    logic [CNT_W-1:0]  cnt_next;
    logic [2:0]        cur_bit;
    logic              active_next;
    logic              tx_oe;

    // Frame settings: captured at frame sync, used directly on that edge.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rate_q <= '0;
            txs_q  <= '1;
            rxs_q  <= '1;
            txd_q  <= '0;
        end else if (fsync) begin
            rate_q <= rate_sel;
            txs_q  <= tx_slot;
            rxs_q  <= rx_slot;
            txd_q  <= tx_data;
        end
    end

    always_comb begin
        rate_eff       = fsync ? rate_sel : rate_q;
        txs_eff        = fsync ? tx_slot  : txs_q;
        rxs_eff        = fsync ? rx_slot  : rxs_q;
        txd_eff        = fsync ? tx_data  : txd_q;
        frame_len      = (CNT_W + 1)'(frame_bits(rate_eff));
        last_pos       = CNT_W'(frame_len - 1'b1);
        slots_in_frame = (SLOT_W + 1)'(frame_len >> 3);
    end

    pcm_frame_counter #(
        .CNT_W (CNT_W)
    ) u_counter (
        .clk         (clk),
        .rst_n       (rst_n),
        .fsync       (fsync),
        .last_pos    (last_pos),
        .cnt_next    (cnt_next),
        .cur_bit     (cur_bit),
        .active_next (active_next)
    );

    pcm_tx_lane #(
        .CNT_W  (CNT_W),
        .SLOT_W (SLOT_W)
    ) u_tx (
        .clk            (clk),
        .rst_n          (rst_n),
        .active_next    (active_next),
        .cnt_next       (cnt_next),
        .slot           (txs_eff),
        .slots_in_frame (slots_in_frame),
        .load_byte      (txd_eff),
        .dx             (dx),
        .dx_oe          (tx_oe)
    );

    pcm_rx_lane #(
        .CNT_W  (CNT_W),
        .SLOT_W (SLOT_W)
    ) u_rx (
        .clk            (clk),
        .rst_n          (rst_n),
        .active_next    (active_next),
        .cnt_next       (cnt_next),
        .cur_bit        (cur_bit),
        .slot           (rxs_eff),
        .slots_in_frame (slots_in_frame),
        .dr             (dr),
        .rx_data        (rx_data),
        .rx_valid       (rx_valid)
    );

    // Open-drain strobe model: pulled low only while the data pin drives.
    always_comb begin
        dx_oe = tx_oe;
        tsx_n = ~tx_oe;
    end

endmodule

// File: rtl/pcm_slot_port_chk.sv
`timescale 1ns/1ps
module pcm_slot_port_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       fsync,
    input logic       dx_oe,
    input logic [7:0] rx_data,
    input logic       rx_valid
);

    logic       seen_sync_q;
    logic [3:0] oe_run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_sync_q <= 1'b0;
            oe_run_q    <= '0;
        end else begin
            if (fsync) seen_sync_q <= 1'b1;
            if (fsync || !dx_oe) begin
                oe_run_q <= '0;
            end else if (oe_run_q != 4'hF) begin
                oe_run_q <= oe_run_q + 4'd1;
            end
        end
    end

    p_quiet_before_sync_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !seen_sync_q |-> (!dx_oe && !rx_valid));

    p_tx_burst_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
        dx_oe |-> (oe_run_q < 4'd8));

    p_valid_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    p_rx_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid |-> $stable(rx_data));

endmodule

bind pcm_slot_port pcm_slot_port_chk u_pcm_slot_port_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .fsync    (fsync),
    .dx_oe    (dx_oe),
    .rx_data  (rx_data),
    .rx_valid (rx_valid)
);

// File: tb/test_pcm_slot_port.sv
`timescale 1ns/1ps
module test_pcm_slot_port;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       fsync;
    logic [1:0] rate_sel;
    logic [7:0] tx_slot;
    logic [7:0] rx_slot;
    logic [7:0] tx_data;
    logic       dr;
    logic       dx;
    logic       dx_oe;
    logic       tsx_n;
    logic [7:0] rx_data;
    logic       rx_valid;

    int total = 0;
    int bad   = 0;

    // State carried from the previous frame into the next frame-sync cycle.
    bit       p_ten  = 1'b0;
    int       p_ts   = 0;
    logic [7:0] p_tb = '0;
    bit       p_pend = 1'b0;
    logic [7:0] p_rb = '0;
    logic [7:0] exp_rx = '0;

    always #4 clk = ~clk;

    pcm_slot_port i_pcm_slot_port (
        .clk      (clk),
        .rst_n    (rst_n),
        .fsync    (fsync),
        .rate_sel (rate_sel),
        .tx_slot  (tx_slot),
        .rx_slot  (rx_slot),
        .tx_data  (tx_data),
        .dr       (dr),
        .dx       (dx),
        .dx_oe    (dx_oe),
        .tsx_n    (tsx_n),
        .rx_data  (rx_data),
        .rx_valid (rx_valid)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic run_frame(input int rate, input int ts, input int rs,
                             input logic [7:0] tb, input logic [7:0] rb);
        int len;
        bit ten;
        bit ren;
        bit oe;
        bit vexp;
        len = (rate == 0) ? 192 : (256 << (rate - 1));
        ten = (ts < len / 8);
        ren = (rs < len / 8);
        // Frame-sync cycle: this is wrapped position 0 of the previous frame (R2).
        @(posedge clk);
        #1;
        fsync    = 1'b1;
        rate_sel = 2'(rate);
        tx_slot  = 8'(ts);
        rx_slot  = 8'(rs);
        tx_data  = tb;
        dr       = 1'b1;
        #2;
        oe = p_ten && (p_ts == 0);
        check(dx_oe == oe, "R2 wrap oe", int'(dx_oe), int'(oe));
        if (oe) check(dx == p_tb[7], "R2 wrap dx", int'(dx), int'(p_tb[7]));
        check(rx_valid == p_pend, "R2 wrap valid", int'(rx_valid), int'(p_pend));
        if (p_pend) exp_rx = p_rb;
        check(rx_data == exp_rx, "R2 wrap data", int'(rx_data), int'(exp_rx));
        for (int pos = 0; pos < len; pos++) begin
            @(posedge clk);
            #1;
            fsync = 1'b0;
            if (pos == 1) begin
                tx_data  = ~tb;
                tx_slot  = 8'(ts ^ 1);
                rx_slot  = 8'(rs ^ 1);
                rate_sel = ~2'(rate);
            end
            if (ren && (pos / 8 == rs)) dr = rb[7 - (pos % 8)];
            else                        dr = ~rb[7 - (pos % 8)] ^ pos[4];
            #2;
            oe = ten && (pos / 8 == ts);
            check(dx_oe == oe, ten ? "R3 R9 oe" : "R8 tx off", int'(dx_oe), int'(oe));
            check(tsx_n == !oe, "R4 strobe", int'(tsx_n), int'(!oe));
            if (oe) check(dx == tb[7 - (pos % 8)], "R3 R5 dx", int'(dx), int'(tb[7 - (pos % 8)]));
            vexp = ren && (pos == 8 * rs + 8);
            if (vexp) exp_rx = rb;
            check(rx_valid == vexp, ren ? "R6 R9 valid" : "R8 rx off", int'(rx_valid), int'(vexp));
            check(rx_data == exp_rx, "R6 R7 data", int'(rx_data), int'(exp_rx));
        end
        p_ten  = ten;
        p_ts   = ts;
        p_tb   = tb;
        p_pend = ren && (rs == len / 8 - 1);
        p_rb   = rb;
    endtask

    initial begin
        #(8 * 150000);
        total++;
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int len;
        rst_n    = 1'b0;
        fsync    = 1'b0;
        rate_sel = 2'd0;
        tx_slot  = 8'd0;
        rx_slot  = 8'd0;
        tx_data  = 8'hA5;
        dr       = 1'b0;
        repeat (3) @(posedge clk);
        #3;
        check(dx_oe == 1'b0, "R1 oe", int'(dx_oe), 0);
        check(tsx_n == 1'b1, "R1 strobe", int'(tsx_n), 1);
        check(rx_valid == 1'b0, "R1 valid", int'(rx_valid), 0);
        check(rx_data == 8'h00, "R1 data", int'(rx_data), 0);
        @(negedge clk);
        rst_n = 1'b1;
        // No frame sync yet: busy inputs must produce nothing.
        for (int i = 0; i < 300; i++) begin
            @(posedge clk);
            #1;
            dr      = i[0] ^ i[2];
            tx_data = 8'(i);
            tx_slot = 8'(i % 3);
            rx_slot = 8'(i % 5);
            #2;
            check(dx_oe == 1'b0 && tsx_n == 1'b1, "R1 hunt oe", int'(dx_oe), 0);
            check(rx_valid == 1'b0 && rx_data == 8'h00, "R1 hunt rx", int'(rx_data), 0);
        end
        // Corner slot pairs at every rate.
        for (int r = 0; r < 4; r++) begin
            len = (r == 0) ? 192 : (256 << (r - 1));
            run_frame(r, 0, len / 8 - 1, 8'h96, 8'h3C);
            run_frame(r, len / 8 - 1, 0, 8'h81, 8'hE7);
            run_frame(r, 3, 3, 8'h5A, 8'hC3);
            run_frame(r, len / 8, 5, 8'hFF, 8'h12);
            run_frame(r, 2, len / 8, 8'h01, 8'hFE);
            run_frame(r, 255, 255, 8'h77, 8'h88);
        end
        // Sweep all transmit slots of the short frame.
        for (int s = 0; s < 25; s++) begin
            run_frame(0, s, (s * 7) % 25, 8'(s * 37 + 11), 8'(s * 53 + 7));
        end
        run_frame(1, 200, 200, 8'h00, 8'h00);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule